// File: doc/BRIEF.md
# Vertical Transfer and Frame Timing Sequencer for an Interline CCD

This block produces the line and frame rhythm for a progressive-scan interline CCD. A pixel-period counter runs across each line and a line counter runs across each frame. From those counters it decodes level codes for the two vertical phase clocks. Off-chip level shifters turn these codes into the real drive voltages. It also produces a line strobe, a frame strobe and a horizontal-readout window.

Phase 2 has three levels. It idles at mid. Once per frame it pulses to the high level, which moves photodiode charge into the vertical registers. Each line then performs a complementary two-phase transfer: phase 2 drops to low while phase 1 lifts to mid. The readout window opens only after both phases have returned to idle and a programmable guard interval has passed.

Every duration is given in system clock cycles on input ports. The block captures them once per frame, so the timing of a frame is fixed for its whole length.

Top module: `ccd_vseq_top`

## Requirements
- R1: While rst_ni is low, v1_code_o is 00 (low), v2_code_o is 01 (mid), and line_start_o, frame_start_o and h_active_o are 0. The first rising clock edge after release captures the configuration. The following cycle is pixel 0 of line 0, with frame_start_o high.
- R2: line_start_o is high for one cycle at pixel 0 of every line. A line lasts line_len_i cycles and a frame holds frame_lines_i lines. frame_start_o is high only together with line_start_o, at line 0.
- R3: In line 0 only, v2_code_o is 10 (high) for high_len_i cycles, starting at pixel ped_len_i.
- R4: The line transfer starts at pixel offset X, where X = 2*ped_len_i + high_len_i in line 0 and X = 0 in every other line. From X, v2_code_o is 00 (low) for v2_len_i cycles and v1_code_o is 01 (mid) for v1_len_i cycles. Outside these windows and the high pulse, v1_code_o is 00 and v2_code_o is 01.
- R5: h_active_o is high from pixel X + max(v1_len_i, v2_len_i) + h_gap_i up to the last pixel of the line, and low elsewhere. It is never high while either phase code differs from its idle value.
- R6: v1_code_o takes only 00 or 01, and v2_code_o never takes 11. If the transfer fits within the line, the two phase codes never both rise or both fall in the same cycle.
- R7: Configuration inputs are captured only on the clock edge that starts a frame. A change during a frame has no effect until the next frame.
- R8: If the computed readout start of line 0 is at or beyond line_len_i, h_active_o stays low for all of line 0. Later lines still open their windows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| line_len_i | input | 16 | Cycles per line |
| frame_lines_i | input | 12 | Lines per frame |
| ped_len_i | input | 16 | Guard cycles on each side of the phase-2 high pulse |
| high_len_i | input | 16 | Length of the phase-2 high pulse in cycles |
| v1_len_i | input | 16 | Cycles phase 1 stays mid during a line transfer |
| v2_len_i | input | 16 | Cycles phase 2 stays low during a line transfer |
| h_gap_i | input | 16 | Cycles from the last vertical edge to readout start |
| v1_code_o | output | 2 | Phase-1 level code (00 low, 01 mid) |
| v2_code_o | output | 2 | Phase-2 level code (00 low, 01 mid, 10 high) |
| line_start_o | output | 1 | One-cycle strobe at pixel 0 of each line |
| frame_start_o | output | 1 | One-cycle strobe at pixel 0 of line 0 |
| h_active_o | output | 1 | Horizontal readout window |

## Verification
The bench models each cycle of a frame from the programmed durations and compares every output against that model. Each configuration runs over two whole frames.

The first corner case is the long offset of line 0. A design that forgets to delay the transfer past the high pulse would overlap low and high on phase 2, or open readout too early. The second is a configuration change in the middle of a frame. A design that does not capture its settings only at frame start would show a wrong line length partway through the frame.

The bench also runs a line 0 whose readout start falls beyond the line end; a wrapping comparator would assert the window there. An asynchronous reset in mid-frame must return the codes to idle at once.

// File: rtl/ccd_vseq_pkg.sv
package ccd_vseq_pkg;
  localparam int PIX_W  = 16;
  localparam int LINE_W = 12;
  localparam int SUM_W  = PIX_W + 3;

  typedef enum logic [1:0] {
    VL_LOW  = 2'b00,
    VL_MID  = 2'b01,
    VL_HIGH = 2'b10
  } vlvl_e;

  typedef struct packed {
    logic [PIX_W-1:0]  line_len;
    logic [LINE_W-1:0] frame_lines;
    logic [PIX_W-1:0]  ped_len;
    logic [PIX_W-1:0]  high_len;
    logic [PIX_W-1:0]  v1_len;
    logic [PIX_W-1:0]  v2_len;
    logic [PIX_W-1:0]  h_gap;
  } vcfg_t;
endpackage

// File: rtl/ccd_vseq_cfg.sv
module ccd_vseq_cfg
  import ccd_vseq_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  load_i,
  input  vcfg_t cfg_i,
  output vcfg_t cfg_o
);
  vcfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cfg_q <= '0;
    else if (load_i) cfg_q <= cfg_i;
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/ccd_vseq_timer.sv
module ccd_vseq_timer
  import ccd_vseq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PIX_W-1:0]  line_len_i,
  input  logic [LINE_W-1:0] frame_lines_i,
  output logic              run_o,
  output logic              load_o,
  output logic [PIX_W-1:0]  pix_o,
  output logic [LINE_W-1:0] line_o
);
  localparam logic [PIX_W-1:0]  PIX_ONE  = PIX_W'(1);
  localparam logic [LINE_W-1:0] LINE_ONE = LINE_W'(1);

  logic              run_q;
  logic [PIX_W-1:0]  pix_q;
  logic [LINE_W-1:0] line_q;
  logic              eol, eof;

  assign eol = (pix_q == line_len_i - PIX_ONE);
  assign eof = (line_q == frame_lines_i - LINE_ONE);

  // first cycle out of reset only loads configuration
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      pix_q  <= '0;
      line_q <= '0;
    end else if (!run_q) begin
      run_q  <= 1'b1;
      pix_q  <= '0;
      line_q <= '0;
    end else if (eol) begin
      pix_q  <= '0;
      line_q <= eof ? '0 : line_q + LINE_ONE;
    end else begin
      pix_q  <= pix_q + PIX_ONE;
    end
  end

  assign run_o  = run_q;
  assign load_o = !run_q || (eol && eof);
  assign pix_o  = pix_q;
  assign line_o = line_q;

  a_r2_pix_in_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && line_len_i != '0) |-> (pix_q < line_len_i));

  a_r2_line_in_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && frame_lines_i != '0) |-> (line_q < frame_lines_i));
endmodule

// File: rtl/ccd_vseq_vgen.sv
module ccd_vseq_vgen
  import ccd_vseq_pkg::*;
(
  input  logic             run_i,
  input  logic             line_zero_i,
  input  logic [PIX_W-1:0] pix_i,
  input  logic [PIX_W-1:0] ped_len_i,
  input  logic [PIX_W-1:0] high_len_i,
  input  logic [PIX_W-1:0] v1_len_i,
  input  logic [PIX_W-1:0] v2_len_i,
  input  logic [PIX_W-1:0] h_gap_i,
  output logic [1:0]       v1_code_o,
  output logic [1:0]       v2_code_o,
  output logic             h_active_o
);
  logic [SUM_W-1:0] p, ped, hi, v1, v2, gap;
  logic [SUM_W-1:0] xoff, vmax, hstart;
  logic             in_hi, in_v1, in_v2;

  assign p   = SUM_W'(pix_i);
  assign ped = SUM_W'(ped_len_i);
  assign hi  = SUM_W'(high_len_i);
  assign v1  = SUM_W'(v1_len_i);
  assign v2  = SUM_W'(v2_len_i);
  assign gap = SUM_W'(h_gap_i);

  always_comb begin
    // line 0 shifts its transfer behind the readout pulse and both guards
    xoff   = line_zero_i ? (ped + ped + hi) : '0;
    vmax   = (v1 > v2) ? v1 : v2;
    hstart = xoff + vmax + gap;
    in_hi  = line_zero_i && (p >= ped) && (p < ped + hi);
    in_v2  = (p >= xoff) && (p < xoff + v2);
    in_v1  = (p >= xoff) && (p < xoff + v1);

    v2_code_o = VL_MID;
    if (run_i && in_hi)      v2_code_o = VL_HIGH;
    else if (run_i && in_v2) v2_code_o = VL_LOW;

    v1_code_o  = (run_i && in_v1) ? VL_MID : VL_LOW;
    h_active_o = run_i && (p >= hstart);
  end
endmodule

// File: rtl/ccd_vseq_top.sv
module ccd_vseq_top
  import ccd_vseq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PIX_W-1:0]  line_len_i,
  input  logic [LINE_W-1:0] frame_lines_i,
  input  logic [PIX_W-1:0]  ped_len_i,
  input  logic [PIX_W-1:0]  high_len_i,
  input  logic [PIX_W-1:0]  v1_len_i,
  input  logic [PIX_W-1:0]  v2_len_i,
  input  logic [PIX_W-1:0]  h_gap_i,
  output logic [1:0]        v1_code_o,
  output logic [1:0]        v2_code_o,
  output logic              line_start_o,
  output logic              frame_start_o,
  output logic              h_active_o
);
  vcfg_t             cfg_in, cfg_q;
  logic              run, load, line_zero;
  logic [PIX_W-1:0]  pix;
  logic [LINE_W-1:0] line;

  assign cfg_in = '{line_len: line_len_i, frame_lines: frame_lines_i,
                    ped_len: ped_len_i, high_len: high_len_i,
                    v1_len: v1_len_i, v2_len: v2_len_i, h_gap: h_gap_i};

  ccd_vseq_cfg u_cfg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load),
    .cfg_i (cfg_in),
    .cfg_o (cfg_q)
  );

  ccd_vseq_timer u_timer (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .line_len_i   (cfg_q.line_len),
    .frame_lines_i(cfg_q.frame_lines),
    .run_o        (run),
    .load_o       (load),
    .pix_o        (pix),
    .line_o       (line)
  );

  assign line_zero = (line == '0);

  ccd_vseq_vgen u_vgen (
    .run_i      (run),
    .line_zero_i(line_zero),
    .pix_i      (pix),
    .ped_len_i  (cfg_q.ped_len),
    .high_len_i (cfg_q.high_len),
    .v1_len_i   (cfg_q.v1_len),
    .v2_len_i   (cfg_q.v2_len),
    .h_gap_i    (cfg_q.h_gap),
    .v1_code_o  (v1_code_o),
    .v2_code_o  (v2_code_o),
    .h_active_o (h_active_o)
  );

  assign line_start_o  = run && (pix == '0);
  assign frame_start_o = line_start_o && line_zero;

  a_r2_frame_on_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |-> line_start_o);

  a_r3_high_in_line0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v2_code_o == VL_HIGH) |-> line_zero);

  a_r5_read_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    h_active_o |-> (v1_code_o == VL_LOW && v2_code_o == VL_MID));

  a_r6_legal_codes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v1_code_o != VL_HIGH) && (v1_code_o != 2'b11) && (v2_code_o != 2'b11));

  a_r6_no_same_dir: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((v1_code_o > $past(v1_code_o)) && (v2_code_o > $past(v2_code_o))) &&
    !((v1_code_o < $past(v1_code_o)) && (v2_code_o < $past(v2_code_o))));

  a_r7_cfg_at_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cfg_q) |-> frame_start_o);
endmodule

// File: tb/ccd_vseq_top_tb_top.sv
`timescale 1ns/1ps
module ccd_vseq_top_tb_top;
  import ccd_vseq_pkg::PIX_W;
  import ccd_vseq_pkg::LINE_W;

  typedef struct packed {
    int len; int lines; int ped; int hi; int v1; int v2; int gap;
  } tcfg_t;

  localparam int NVEC = 4;
  // len lines ped hi v1 v2 gap ; last entry has no readout window in line 0 (R8)
  localparam tcfg_t VEC [0:NVEC-1] = '{
    '{24, 3, 2, 3, 4, 3, 2},
    '{40, 5, 4, 10, 3, 5, 6},
    '{16, 2, 1, 1, 1, 1, 0},
    '{30, 4, 6, 8, 4, 4, 8}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [PIX_W-1:0]  line_len, ped_len, high_len, v1_len, v2_len, h_gap;
  logic [LINE_W-1:0] frame_lines;
  logic [1:0] v1_code, v2_code;
  logic line_start, frame_start, h_active;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int bad [0:8];
  int fa  [0:8];
  int fe  [0:8];

  always #10 clk = ~clk;

  ccd_vseq_top dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .line_len_i(line_len), .frame_lines_i(frame_lines),
    .ped_len_i(ped_len), .high_len_i(high_len),
    .v1_len_i(v1_len), .v2_len_i(v2_len), .h_gap_i(h_gap),
    .v1_code_o(v1_code), .v2_code_o(v2_code),
    .line_start_o(line_start), .frame_start_o(frame_start), .h_active_o(h_active)
  );

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  function automatic string rq(int r);
    case (r)
      2: return "R2";
      3: return "R3";
      4: return "R4";
      5: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic note(int r, int a, int e);
    if (bad[r] == 0) begin fa[r] = a; fe[r] = e; end
    bad[r]++;
  endtask

  task automatic drive(tcfg_t c);
    line_len    = c.len[PIX_W-1:0];
    frame_lines = c.lines[LINE_W-1:0];
    ped_len     = c.ped[PIX_W-1:0];
    high_len    = c.hi[PIX_W-1:0];
    v1_len      = c.v1[PIX_W-1:0];
    v2_len      = c.v2[PIX_W-1:0];
    h_gap       = c.gap[PIX_W-1:0];
  endtask

  task automatic chk_idle(string what);
    // R1: idle codes, no strobes
    chk(v1_code == 2'b00, "R1", {what, " v1"}, int'(v1_code), 0);
    chk(v2_code == 2'b01, "R1", {what, " v2"}, int'(v2_code), 1);
    chk({line_start, frame_start, h_active} == 3'b000, "R1", {what, " strobes"},
        int'({line_start, frame_start, h_active}), 0);
  endtask

  task automatic do_reset(tcfg_t c);
    @(negedge clk);
    rst_ni = 1'b0;
    drive(c);
    repeat (3) @(negedge clk);
    chk_idle("in reset");
    rst_ni = 1'b1;
    @(negedge clk);
    chk(frame_start == 1'b1, "R1", "frame_start after release", int'(frame_start), 1);
  endtask

  task automatic model(tcfg_t c, int p, int l, output int e1, output int e2, output int eh);
    int xoff = (l == 0) ? 2 * c.ped + c.hi : 0;
    int vm = (c.v1 > c.v2) ? c.v1 : c.v2;
    if (l == 0 && p >= c.ped && p < c.ped + c.hi) e2 = 2;
    else if (p >= xoff && p < xoff + c.v2)        e2 = 0;
    else                                          e2 = 1;
    e1 = (p >= xoff && p < xoff + c.v1) ? 1 : 0;
    eh = (p >= xoff + vm + c.gap) ? 1 : 0;
  endtask

  // entered at the negedge of a frame_start cycle, leaves at the next one
  task automatic check_frame(tcfg_t c, tcfg_t nxt, int chg_at, string tag);
    int h0 = 0;
    int pv1 = 0;
    int pv2 = 1;
    for (int r = 0; r <= 8; r++) bad[r] = 0;
    for (int k = 0; k < c.len * c.lines; k++) begin
      int p = k % c.len;
      int l = k / c.len;
      int a1 = int'(v1_code);
      int a2 = int'(v2_code);
      int e1, e2, eh;
      model(c, p, l, e1, e2, eh);
      if (a1 != e1) note(4, a1, e1);
      if (a2 != e2) note((a2 == 2 || e2 == 2) ? 3 : 4, a2, e2);
      if (int'(h_active) != eh) note(5, int'(h_active), eh);
      if (int'(line_start) != int'(p == 0)) note(2, int'(line_start), int'(p == 0));
      if (int'(frame_start) != int'(k == 0)) note(2, int'(frame_start), int'(k == 0));
      if (a1 > 1 || a2 > 2) note(6, a1 * 4 + a2, 0);
      if (k > 0 && ((a1 > pv1 && a2 > pv2) || (a1 < pv1 && a2 < pv2)))
        note(6, a1 * 4 + a2, pv1 * 4 + pv2);
      if (l == 0 && h_active) h0++;
      pv1 = a1;
      pv2 = a2;
      if (k == chg_at) drive(nxt);
      @(negedge clk);
    end
    chk(frame_start == 1'b1, "R2", {tag, " frame period"}, int'(frame_start), 1);
    for (int r = 2; r <= 6; r++)
      chk(bad[r] == 0, rq(r), {tag, " first mismatch"}, fa[r], fe[r]);
    if (2 * c.ped + c.hi + ((c.v1 > c.v2) ? c.v1 : c.v2) + c.gap >= c.len)
      chk(h0 == 0, "R8", {tag, " line0 window count"}, h0, 0);
  endtask

  initial begin
    drive(VEC[0]);
    // table walk: two frames per configuration
    for (int i = 0; i < NVEC; i++) begin
      do_reset(VEC[i]);
      check_frame(VEC[i], VEC[i], -1, $sformatf("vec%0d f0", i));
      check_frame(VEC[i], VEC[i], -1, $sformatf("vec%0d f1", i));
    end

    // R7: change inputs mid-frame, old timing must hold until next frame
    do_reset(VEC[0]);
    check_frame(VEC[0], VEC[1], 5, "r7 old frame");
    check_frame(VEC[1], VEC[1], -1, "r7 new frame");

    // R1: asynchronous reset mid-frame forces idle at once
    do_reset(VEC[2]);
    repeat (5) @(negedge clk);
    #3 rst_ni = 1'b0;
    #1 chk_idle("async reset");
    do_reset(VEC[2]);
    check_frame(VEC[2], VEC[2], -1, "after async reset");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R2 watchdog act=0 exp=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule